// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This block keeps the three condition flags of one port of a switch-fabric processor: two general-purpose flags, A and B, and a control flag, C. It has two jobs. It tests a 2-bit predicate code against the current flags, and it carries out the flag-update instruction. In that instruction, each flag's new value is the logical OR of the literals picked by a 6-bit mask. The literals are A, not A, B, not B, C and not C. With these masks one instruction can clear or set a flag, copy one flag into another, complement a flag, or leave every flag as it is.

The C flag also has a source outside the instruction stream, and which source applies depends on the port type. This is fixed by a parameter.
- On an output-type port, C follows the control value supplied by the attached functional unit on every cycle.
- On an input-type port, C captures a spare address bit that arrives with each received item, on that item's receive strobe.

All pins are plain control and status signals. The block has no valid/ready stream interface and exerts no back-pressure: each strobe is taken in the cycle it is presented. The predicate result is combinational from the predicate code and the registered flags. Flag writes take effect at the next rising clock edge.

Top module: `cond_flag_unit`

## Requirements
- R1: `pred_true` is combinational from `pred_code` and the current flags. Code 2'b00 gives A, 2'b10 gives B, 2'b01 gives C, and 2'b11 gives 1 regardless of the flags.
- R2: When `upd_en` is high and `pred_true` is high, each flag takes the OR of the literals selected by its mask at the next edge. The mask bit order is bit 5 = A, bit 4 = not A, bit 3 = B, bit 2 = not B, bit 1 = C, bit 0 = not C.
- R3: A mask of all zeros writes 0. A mask that selects a flag together with its complement (6'b110000, 6'b001100 or 6'b000011) writes 1.
- R4: The masks 6'b100000 for A, 6'b001000 for B and 6'b000010 for C leave all three flags unchanged.
- R5: When `upd_en` is high and `pred_true` is low, the update is ignored and A and B keep their values.
- R6: All three new values are computed from the flag values held before the edge. For example, mask_a = 6'b001000 with mask_b = 6'b100000 swaps A and B.
- R7: With `PORT_IS_INPUT` = 0, C takes `unit_ctl` at every edge that applies no flag update, and the receive pins have no effect.
- R8: With `PORT_IS_INPUT` = 1, C takes `rx_addr_bit` at an edge where `rx_stb` is high and no flag update applies. Otherwise C holds, and `unit_ctl` has no effect.
- R9: A and B change only through an applied flag update. `unit_ctl`, `rx_stb` and `rx_addr_bit` never change them.
- R10: When a flag update and a port-side C load occur at the same edge, the flag update sets C.
- R11: While `rst_n` is low, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_code | input | 2 | Predicate code to evaluate |
| upd_en | input | 1 | Flag-update instruction strobe |
| mask_a | input | 6 | Literal select mask for the new A |
| mask_b | input | 6 | Literal select mask for the new B |
| mask_c | input | 6 | Literal select mask for the new C |
| unit_ctl | input | 1 | Control value from the attached unit (output-type port) |
| rx_stb | input | 1 | Receive strobe for the spare address bit (input-type port) |
| rx_addr_bit | input | 1 | Spare address bit of the received item |
| pred_true | output | 1 | Predicate result |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Flag C |

## Verification
The assertions check the following on every cycle:
- the always-true predicate code;
- that A and B do not move when the predicate is false or no update is strobed;
- that an all-zero mask clears its flag;
- that an update wins over the port-side C source;
- the C source rule for the port type in use.

Only the bench's scenarios can show the full sum-of-literals function. It sweeps all 64 masks over all eight flag states, with both identical and crossed masks per flag. It also checks the A/B swap, which shows that all three flags update at once, and the no-op mask set. Both port types are instantiated side by side, so the bench can observe each ignoring the other's C source.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int unsigned NFLAG = 3;
  localparam int unsigned LIT_W = 2 * NFLAG;
  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_B = 1;
  localparam int unsigned IDX_C = 2;

  typedef enum logic [1:0] {
    PR_A   = 2'b00,
    PR_C   = 2'b01,
    PR_B   = 2'b10,
    PR_ANY = 2'b11
  } pred_e;
endpackage

// File: rtl/cfu_lit_expand.sv
module cfu_lit_expand
  import cfu_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  output logic [LIT_W-1:0] lits
);
  // flag i occupies the pair (true, complement) starting at the MSB side
  for (genvar i = 0; i < NFLAG; i++) begin : g_pair
    assign lits[LIT_W-1-2*i] = flags[i];
    assign lits[LIT_W-2-2*i] = ~flags[i];
  end
endmodule

// File: rtl/cfu_lit_or.sv
module cfu_lit_or
  import cfu_pkg::*;
(
  input  logic [LIT_W-1:0] mask,
  input  logic [LIT_W-1:0] lits,
  output logic             value
);
  assign value = |(mask & lits);
endmodule

// File: rtl/cfu_pred_eval.sv
module cfu_pred_eval
  import cfu_pkg::*;
(
  input  logic [1:0]       code,
  input  logic [NFLAG-1:0] flags,
  output logic             hit
);
  always_comb begin
    unique case (pred_e'(code))
      PR_A:    hit = flags[IDX_A];
      PR_B:    hit = flags[IDX_B];
      PR_C:    hit = flags[IDX_C];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfu_ctl_src.sv
module cfu_ctl_src #(
  parameter bit PORT_IS_INPUT = 1'b0
) (
  input  logic unit_ctl,
  input  logic rx_stb,
  input  logic rx_addr_bit,
  output logic c_load,
  output logic c_val
);
  if (PORT_IS_INPUT) begin : g_in
    logic unused_ok;
    assign unused_ok = unit_ctl;
    assign c_load    = rx_stb;
    assign c_val     = rx_addr_bit;
  end else begin : g_out
    logic unused_ok;
    assign unused_ok = rx_stb ^ rx_addr_bit;
    assign c_load    = 1'b1;
    assign c_val     = unit_ctl;
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter bit PORT_IS_INPUT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pred_code,
  input  logic       upd_en,
  input  logic [5:0] mask_a,
  input  logic [5:0] mask_b,
  input  logic [5:0] mask_c,
  input  logic       unit_ctl,
  input  logic       rx_stb,
  input  logic       rx_addr_bit,
  output logic       pred_true,
  output logic       flag_a,
  output logic       flag_b,
  output logic       flag_c
);
  logic [NFLAG-1:0]            fl_q;
  logic [NFLAG-1:0]            fl_nxt;
  logic [LIT_W-1:0]            lits;
  logic [NFLAG-1:0][LIT_W-1:0] masks;
  logic                        upd;
  logic                        c_load;
  logic                        c_val;

  assign masks[IDX_A] = mask_a;
  assign masks[IDX_B] = mask_b;
  assign masks[IDX_C] = mask_c;

  cfu_pred_eval u_pred (.code(pred_code), .flags(fl_q), .hit(pred_true));

  cfu_lit_expand u_lit (.flags(fl_q), .lits(lits));

  // one OR-of-literals evaluator per flag, all fed from the old flag values
  for (genvar f = 0; f < NFLAG; f++) begin : g_next
    cfu_lit_or u_or (.mask(masks[f]), .lits(lits), .value(fl_nxt[f]));
  end

  cfu_ctl_src #(.PORT_IS_INPUT(PORT_IS_INPUT)) u_csrc (
    .unit_ctl(unit_ctl), .rx_stb(rx_stb), .rx_addr_bit(rx_addr_bit),
    .c_load(c_load), .c_val(c_val)
  );

  assign upd = upd_en & pred_true;

  // an applied update has priority over the port-side C source
  always_ff @(posedge clk) begin
    if (!rst_n)      fl_q        <= '0;
    else if (upd)    fl_q        <= fl_nxt;
    else if (c_load) fl_q[IDX_C] <= c_val;
  end

  assign flag_a = fl_q[IDX_A];
  assign flag_b = fl_q[IDX_B];
  assign flag_c = fl_q[IDX_C];

  assert_always_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_code == 2'b11) |-> pred_true);

  assert_false_pred_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !pred_true) |=> (flag_a == $past(flag_a)) && (flag_b == $past(flag_b)));

  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mask_a == 6'b000000) |=> !flag_a);

  assert_ab_only_by_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flag_a) && $stable(flag_b));

  assert_update_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mask_c == 6'b000011) |=> flag_c);

  if (PORT_IS_INPUT) begin : g_chk_in
    assert_c_from_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && rx_stb) |=> flag_c == $past(rx_addr_bit));
    assert_c_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !rx_stb) |=> $stable(flag_c));
  end else begin : g_chk_out
    assert_c_from_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> flag_c == $past(unit_ctl));
  end
endmodule

// File: tb/sim_cond_flag_unit.sv
module sim_cond_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pred_code = 2'b11;
  logic       upd_en = 1'b0;
  logic [5:0] mask_a = '0, mask_b = '0, mask_c = '0;
  logic       unit_ctl = 1'b0, rx_stb = 1'b0, rx_addr_bit = 1'b0;
  logic       pt0, a0, b0, c0, pt1, a1, b1, c1;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  // u0: output-type port, u1: input-type port
  cond_flag_unit #(.PORT_IS_INPUT(1'b0)) u0 (
    .clk, .rst_n, .pred_code, .upd_en, .mask_a, .mask_b, .mask_c,
    .unit_ctl, .rx_stb, .rx_addr_bit,
    .pred_true(pt0), .flag_a(a0), .flag_b(b0), .flag_c(c0));
  cond_flag_unit #(.PORT_IS_INPUT(1'b1)) u1 (
    .clk, .rst_n, .pred_code, .upd_en, .mask_a, .mask_b, .mask_c,
    .unit_ctl, .rx_stb, .rx_addr_bit,
    .pred_true(pt1), .flag_a(a1), .flag_b(b1), .flag_c(c1));

  function automatic logic nx(input logic [5:0] m, input logic a, b, c);
    return |(m & {a, ~a, b, ~b, c, ~c});
  endfunction

  function automatic logic pexp(input logic [1:0] p, input logic a, b, c);
    case (p)
      2'b00:   return a;
      2'b10:   return b;
      2'b01:   return c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk3(input string tag, input logic ea, eb, ec);
    chk({tag, " u0.A"}, a0, ea); chk({tag, " u0.B"}, b0, eb); chk({tag, " u0.C"}, c0, ec);
    chk({tag, " u1.A"}, a1, ea); chk({tag, " u1.B"}, b1, eb); chk({tag, " u1.C"}, c1, ec);
  endtask

  // uc is the value unit_ctl keeps afterwards (so u0's C stays put)
  task automatic apply(input logic [1:0] p, input logic [5:0] ma, mb, mc, input logic uc);
    @(negedge clk);
    pred_code = p; mask_a = ma; mask_b = mb; mask_c = mc; upd_en = 1'b1; unit_ctl = uc;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic setup(input logic a, b, c);
    apply(2'b11, a ? 6'b110000 : 6'b0, b ? 6'b001100 : 6'b0, c ? 6'b000011 : 6'b0, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk3("R11 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    chk3("R11 after release", 1'b0, 1'b0, 1'b0);

    // R1: every predicate code in every flag state
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 4; p++) begin
        setup(s[2], s[1], s[0]);
        pred_code = p[1:0];
        #1;
        chk("R1 u0 pred", pt0, pexp(p[1:0], s[2], s[1], s[0]));
        chk("R1 u1 pred", pt1, pexp(p[1:0], s[2], s[1], s[0]));
      end
    end

    // R2: all masks, all states, same and crossed masks per flag
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 64; m++) begin
        logic [5:0] ma, mb, mc;
        logic a, b, c;
        a = s[2]; b = s[1]; c = s[0];
        ma = m[5:0];
        setup(a, b, c);
        apply(2'b11, ma, ma, ma, nx(ma, a, b, c));
        chk3("R2 same mask", nx(ma, a, b, c), nx(ma, a, b, c), nx(ma, a, b, c));
        mb = ma ^ 6'b101010;
        mc = {ma[2:0], ma[5:3]};
        setup(a, b, c);
        apply(2'b11, ma, mb, mc, nx(mc, a, b, c));
        chk3("R2 crossed masks", nx(ma, a, b, c), nx(mb, a, b, c), nx(mc, a, b, c));
      end
    end

    // R5: complementing update under every predicate code and state
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic h;
        h = pexp(p[1:0], s[2], s[1], s[0]);
        setup(s[2], s[1], s[0]);
        apply(p[1:0], 6'b010000, 6'b000100, 6'b000001, h ? ~s[0] : s[0]);
        chk3("R5 predicated update", h ? ~s[2] : s[2], h ? ~s[1] : s[1], h ? ~s[0] : s[0]);
      end
    end

    // R3: constants
    setup(1'b1, 1'b1, 1'b1);
    apply(2'b11, 6'b0, 6'b0, 6'b0, 1'b0);
    chk3("R3 zero masks", 1'b0, 1'b0, 1'b0);
    setup(1'b0, 1'b0, 1'b0);
    apply(2'b11, 6'b110000, 6'b001100, 6'b000011, 1'b1);
    chk3("R3 complement pairs", 1'b1, 1'b1, 1'b1);

    // R4: identity masks
    setup(1'b1, 1'b0, 1'b1);
    apply(2'b11, 6'b100000, 6'b001000, 6'b000010, 1'b1);
    chk3("R4 no-op", 1'b1, 1'b0, 1'b1);

    // R6: swap A and B
    setup(1'b1, 1'b0, 1'b0);
    apply(2'b11, 6'b001000, 6'b100000, 6'b000010, 1'b0);
    chk3("R6 swap", 1'b0, 1'b1, 1'b0);

    // R7 / R9: unit_ctl drives C on the output-type port only
    setup(1'b0, 1'b0, 1'b0);
    @(negedge clk); unit_ctl = 1'b1;
    @(negedge clk);
    chk("R7 u0 C follows unit", c0, 1'b1);
    chk("R8 u1 ignores unit", c1, 1'b0);
    chk("R9 u0 A untouched", a0, 1'b0);
    chk("R9 u0 B untouched", b0, 1'b0);
    unit_ctl = 1'b0;
    @(negedge clk);
    chk("R7 u0 C follows unit low", c0, 1'b0);

    // R8 / R9: spare address bit on the input-type port
    rx_addr_bit = 1'b1;
    @(negedge clk);
    chk("R8 u1 holds without strobe", c1, 1'b0);
    rx_stb = 1'b1;
    @(negedge clk);
    rx_stb = 1'b0;
    chk("R8 u1 C loads rx bit", c1, 1'b1);
    chk("R7 u0 ignores rx", c0, 1'b0);
    chk("R9 u1 A untouched", a1, 1'b0);
    chk("R9 u1 B untouched", b1, 1'b0);
    rx_addr_bit = 1'b0;
    @(negedge clk);
    chk("R8 u1 holds after strobe", c1, 1'b1);

    // R10: update and port-side load in the same edge
    setup(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    pred_code = 2'b11; mask_a = '0; mask_b = '0; mask_c = 6'b000011;
    upd_en = 1'b1; unit_ctl = 1'b0; rx_stb = 1'b1; rx_addr_bit = 1'b0;
    @(negedge clk);
    upd_en = 1'b0; rx_stb = 1'b0;
    chk("R10 u0 update wins", c0, 1'b1);
    chk("R10 u1 update wins", c1, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule